// File: doc/BRIEF.md
# Full-Map Home Directory Controller

This block is the home-node coherence directory for a multiprocessor whose caches are write-back and write-invalidate. It keeps one entry for each memory block. An entry holds a sharer vector, with one bit per processor, and an owner flag that marks the block as modified in a single cache. Read-miss and write-miss requests arrive with the number of the requesting processor and the block number. The controller looks up the entry and decides from it what to do. It may fetch the block from memory, recall the modified copy from its owner, or send invalidations to the other sharers. It then replies to the requester with the data and writes the new entry back.

The controller handles one transaction at a time. Requests and completions use a valid/ready handshake. Outgoing coherence messages leave on a single message port, at most one per cycle. Cache replies come back on a response port: either an invalidation acknowledgement or the recalled line. Memory is reached through a simple read/write strobe that waits for an acknowledge.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset every entry has an empty sharer vector and a clear owner flag, `req_ready_o` is 1, and `msg_valid_o` and `done_o` are 0. The first access to any block therefore causes no recall and no invalidation.
- R2: When the owner flag of an entry is set, exactly one sharer bit is set. After a write miss, only the writer holds the block.
- R3: A read miss to a block whose owner flag is clear reads memory and sends a data message (type 3) with the memory word to the requester. The requester is then added to the sharers.
- R4: A read miss to an owned block sends one recall-to-shared message (type 0) to the owner and waits for a response of kind 1 carrying the line. It writes that line to memory and forwards it to the requester. The owner flag is then clear and both the old owner and the requester are sharers.
- R5: A write miss to a block whose owner flag is clear sends one invalidation (type 2) to each sharer except the requester, one per cycle, and replies with the memory word.
- R6: A write miss that sent invalidations completes only after as many acknowledgements (response kind 0) as invalidations sent have been received.
- R7: A write miss to an owned block sends one recall-and-invalidate message (type 1) to the owner, writes the returned line to memory and forwards it to the requester. The requester then becomes the sole owner.
- R8: `req_ready_o` is 0 from the cycle after a request is accepted until the cycle after `done_o`. Requests are served strictly one at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle, request taken this cycle |
| req_write_i | input | 1 | 1 = write miss, 0 = read miss |
| req_src_i | input | ID_W | Requesting processor |
| req_blk_i | input | BLK_W | Block number |
| msg_valid_o | output | 1 | Message issued this cycle |
| msg_type_o | output | 2 | 0 recall-share, 1 recall-invalidate, 2 invalidate, 3 data |
| msg_dst_o | output | ID_W | Destination processor |
| msg_data_o | output | DATA_W | Payload of data messages |
| rsp_valid_i | input | 1 | Cache response present |
| rsp_kind_i | input | 1 | 0 = invalidation ack, 1 = recalled line |
| rsp_data_i | input | DATA_W | Recalled line |
| mem_rd_o | output | 1 | Memory read strobe, held until ack |
| mem_wr_o | output | 1 | Memory write strobe, held until ack |
| mem_blk_o | output | BLK_W | Memory block number |
| mem_wdata_o | output | DATA_W | Write-back data |
| mem_rdata_i | input | DATA_W | Read data, valid with ack |
| mem_ack_i | input | 1 | Memory access complete |
| done_o | output | 1 | Transaction complete pulse |

## Verification
The bench keeps its own model of every entry and goes through mixed sequences of read and write misses on a few blocks. These sequences reach every path: clean, owned, owner re-requesting, and many sharers. If the requester were not excluded from the invalidation set, an invalidation would go back to the writer and the invalidation mask would not match. If the acknowledgement counter were wrong, the reply would arrive while acknowledgements are still owed. If the recall did not write back, a later clean read would return stale memory. If the owner were not kept as a sharer after a dirty read, a later write would miss an invalidation.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    MSG_RECALL_SHR = 2'd0,
    MSG_RECALL_INV = 2'd1,
    MSG_INVAL      = 2'd2,
    MSG_DATA       = 2'd3
  } msg_e;

  typedef enum logic {
    RSP_ACK  = 1'b0,
    RSP_LINE = 1'b1
  } rsp_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_MEM_RD,
    ST_INVAL,
    ST_WAIT_ACK,
    ST_WAIT_LINE,
    ST_MEM_WR,
    ST_REPLY
  } st_e;
endpackage

// File: rtl/dir_store.sv
module dir_store #(
  parameter int unsigned N_PROC   = 4,
  parameter int unsigned N_BLOCKS = 16,
  localparam int unsigned BLK_W   = $clog2(N_BLOCKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BLK_W-1:0]  rd_blk_i,
  output logic [N_PROC-1:0] rd_pres_o,
  output logic              rd_dirty_o,
  input  logic              wr_en_i,
  input  logic [BLK_W-1:0]  wr_blk_i,
  input  logic [N_PROC-1:0] wr_pres_i,
  input  logic              wr_dirty_i
);
  logic [N_PROC-1:0] pres_q  [N_BLOCKS];
  logic              dirty_q [N_BLOCKS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < int'(N_BLOCKS); b++) begin
        pres_q[b]  <= '0;
        dirty_q[b] <= 1'b0;
      end
    end else if (wr_en_i) begin
      pres_q[wr_blk_i]  <= wr_pres_i;
      dirty_q[wr_blk_i] <= wr_dirty_i;
    end
  end

  assign rd_pres_o  = pres_q[rd_blk_i];
  assign rd_dirty_o = dirty_q[rd_blk_i];

  AST_DIRTY_SOLE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_dirty_i) |-> ($countones(wr_pres_i) == 1)); // R2
endmodule

// File: rtl/dir_first_set.sv
module dir_first_set #(
  parameter int unsigned N_PROC = 4,
  localparam int unsigned ID_W  = $clog2(N_PROC)
) (
  input  logic [N_PROC-1:0] mask_i,
  output logic [ID_W-1:0]   first_o
);
  always_comb begin
    first_o = '0;
    for (int k = int'(N_PROC) - 1; k >= 0; k--) begin
      if (mask_i[k]) first_o = ID_W'(k);
    end
  end
endmodule

// File: rtl/dir_ack_cnt.sv
module dir_ack_cnt #(
  parameter int unsigned N_PROC = 4,
  localparam int unsigned CNT_W = $clog2(N_PROC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_ACK_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> (cnt_q != '0)); // R6
endmodule

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl
  import dir_pkg::*;
#(
  parameter int unsigned N_PROC   = 4,
  parameter int unsigned N_BLOCKS = 16,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned ID_W    = $clog2(N_PROC),
  localparam int unsigned BLK_W   = $clog2(N_BLOCKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ID_W-1:0]   req_src_i,
  input  logic [BLK_W-1:0]  req_blk_i,
  output logic              msg_valid_o,
  output logic [1:0]        msg_type_o,
  output logic [ID_W-1:0]   msg_dst_o,
  output logic [DATA_W-1:0] msg_data_o,
  input  logic              rsp_valid_i,
  input  logic              rsp_kind_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [BLK_W-1:0]  mem_blk_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i,
  output logic              done_o
);
  localparam int unsigned CNT_W = $clog2(N_PROC + 1);

  st_e               st_q, st_d;
  logic [ID_W-1:0]   src_q;
  logic [BLK_W-1:0]  blk_q;
  logic              wr_q;
  logic [N_PROC-1:0] pres_q;
  logic              dirty_q;
  logic [N_PROC-1:0] mask_q, mask_d;
  logic [DATA_W-1:0] data_q, data_d;

  logic [N_PROC-1:0] rd_pres, one_src, inv_set, st_pres;
  logic              rd_dirty, st_wr, accept;
  logic [ID_W-1:0]   owner_id, inv_id;
  logic              ack_load, ack_dec, ack_zero;

  assign accept      = req_valid_i && (st_q == ST_IDLE);
  assign req_ready_o = (st_q == ST_IDLE);

  always_comb begin
    one_src        = '0;
    one_src[src_q] = 1'b1;
  end
  assign inv_set = pres_q & ~one_src;
  assign st_pres = wr_q ? one_src : (pres_q | one_src);

  dir_store #(.N_PROC(N_PROC), .N_BLOCKS(N_BLOCKS)) i_store (
    .clk_i, .rst_ni,
    .rd_blk_i (req_blk_i),
    .rd_pres_o(rd_pres),
    .rd_dirty_o(rd_dirty),
    .wr_en_i  (st_wr),
    .wr_blk_i (blk_q),
    .wr_pres_i(st_pres),
    .wr_dirty_i(wr_q)
  );

  // owner is the single set bit when dirty
  dir_first_set #(.N_PROC(N_PROC)) i_owner (.mask_i(pres_q), .first_o(owner_id));
  dir_first_set #(.N_PROC(N_PROC)) i_inv   (.mask_i(mask_q), .first_o(inv_id));

  assign ack_dec = rsp_valid_i && (rsp_kind_i == RSP_ACK)
                && ((st_q == ST_INVAL) || (st_q == ST_WAIT_ACK));

  dir_ack_cnt #(.N_PROC(N_PROC)) i_acks (
    .clk_i, .rst_ni,
    .load_i    (ack_load),
    .load_val_i(CNT_W'($countones(inv_set))),
    .dec_i     (ack_dec),
    .zero_o    (ack_zero)
  );

  always_comb begin
    st_d        = st_q;
    mask_d      = mask_q;
    data_d      = data_q;
    msg_valid_o = 1'b0;
    msg_type_o  = MSG_DATA;
    msg_dst_o   = src_q;
    mem_rd_o    = 1'b0;
    mem_wr_o    = 1'b0;
    st_wr       = 1'b0;
    ack_load    = 1'b0;
    done_o      = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) st_d = ST_LOOKUP;
      ST_LOOKUP: begin
        if (dirty_q) begin
          msg_valid_o = 1'b1;
          msg_type_o  = wr_q ? MSG_RECALL_INV : MSG_RECALL_SHR;
          msg_dst_o   = owner_id;
          st_d        = ST_WAIT_LINE;
        end else begin
          mask_d   = wr_q ? inv_set : '0;
          ack_load = wr_q;
          st_d     = ST_MEM_RD;
        end
      end
      ST_MEM_RD: begin
        mem_rd_o = 1'b1;
        if (mem_ack_i) begin
          data_d = mem_rdata_i;
          st_d   = (|mask_q) ? ST_INVAL : ST_REPLY;
        end
      end
      ST_INVAL: begin
        msg_valid_o    = 1'b1;
        msg_type_o     = MSG_INVAL;
        msg_dst_o      = inv_id;
        mask_d[inv_id] = 1'b0;
        if (mask_d == '0) st_d = ST_WAIT_ACK;
      end
      ST_WAIT_ACK: if (ack_zero) st_d = ST_REPLY;
      ST_WAIT_LINE: begin
        if (rsp_valid_i && (rsp_kind_i == RSP_LINE)) begin
          data_d = rsp_data_i;
          st_d   = ST_MEM_WR;
        end
      end
      ST_MEM_WR: begin
        mem_wr_o = 1'b1;
        if (mem_ack_i) st_d = ST_REPLY;
      end
      ST_REPLY: begin
        msg_valid_o = 1'b1;
        msg_type_o  = MSG_DATA;
        msg_dst_o   = src_q;
        st_wr       = 1'b1;
        done_o      = 1'b1;
        st_d        = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign msg_data_o  = data_q;
  assign mem_blk_o   = blk_q;
  assign mem_wdata_o = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      src_q   <= '0;
      blk_q   <= '0;
      wr_q    <= 1'b0;
      pres_q  <= '0;
      dirty_q <= 1'b0;
      mask_q  <= '0;
      data_q  <= '0;
    end else begin
      st_q   <= st_d;
      mask_q <= mask_d;
      data_q <= data_d;
      if (accept) begin
        src_q   <= req_src_i;
        blk_q   <= req_blk_i;
        wr_q    <= req_write_i;
        pres_q  <= rd_pres;
        dirty_q <= rd_dirty;
      end
    end
  end

  AST_INV_SKIPS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_type_o == MSG_INVAL) |-> (msg_dst_o != src_q)); // R5
  AST_RECALL_ONLY_OWNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && (msg_type_o == MSG_RECALL_SHR || msg_type_o == MSG_RECALL_INV))
      |-> dirty_q); // R4
  AST_REPLY_AFTER_ACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_type_o == MSG_DATA) |-> ack_zero); // R6
  AST_DONE_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> req_ready_o); // R8
  AST_NO_STROBE_CLASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o)); // R7
endmodule

// File: tb/test_home_dir_ctrl.sv
`timescale 1ns/1ps
module test_home_dir_ctrl;
  localparam int NP = 4;
  localparam int NB = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid = 0, req_ready, req_write = 0;
  logic [1:0]    req_src = '0;
  logic [3:0]    req_blk = '0;
  logic          msg_valid;
  logic [1:0]    msg_type, msg_dst;
  logic [DW-1:0] msg_data;
  logic          rsp_valid = 0, rsp_kind = 0;
  logic [DW-1:0] rsp_data = '0;
  logic          mem_rd, mem_wr, mem_ack = 0;
  logic [3:0]    mem_blk;
  logic [DW-1:0] mem_wdata, mem_rdata = '0;
  logic          done;

  home_dir_ctrl #(.N_PROC(NP), .N_BLOCKS(NB), .DATA_W(DW)) i_home_dir_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_src_i(req_src), .req_blk_i(req_blk),
    .msg_valid_o(msg_valid), .msg_type_o(msg_type), .msg_dst_o(msg_dst), .msg_data_o(msg_data),
    .rsp_valid_i(rsp_valid), .rsp_kind_i(rsp_kind), .rsp_data_i(rsp_data),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_blk_o(mem_blk), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack), .done_o(done)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // bench model
  logic [NP-1:0] m_pres [NB];
  logic          m_dirty[NB];
  logic [DW-1:0] m_mem  [NB];
  int            rec_total = 0;

  // environment observations
  logic [NP-1:0] inv_mask;
  int inv_cnt, rec_seen, rep_seen, ack_pend, acks_given, pend_at_done, busy_viol;
  logic [1:0] rec_dst, rec_type, rep_dst;
  logic [DW-1:0] rep_data, line_val;
  bit line_due = 0, done_seen = 0, busy_win = 0;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  initial begin : env
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (done) begin done_seen = 1; pend_at_done = ack_pend; end
        if (busy_win && req_ready) busy_viol++;
        if (mem_ack) mem_ack = 0;
        else if (mem_rd) begin mem_rdata = m_mem[mem_blk]; mem_ack = 1; end
        else if (mem_wr) begin m_mem[mem_blk] = mem_wdata; mem_ack = 1; end
        rsp_valid = 0;
        if (line_due) begin
          rsp_valid = 1; rsp_kind = 1; rsp_data = line_val; line_due = 0;
        end else if (ack_pend > 0) begin
          rsp_valid = 1; rsp_kind = 0; ack_pend--; acks_given++;
        end
        if (msg_valid) begin
          case (msg_type)
            2'd0, 2'd1: begin
              rec_seen++; rec_dst = msg_dst; rec_type = msg_type;
              line_val = 32'hC0DE_0000 + rec_total; rec_total++; line_due = 1;
            end
            2'd2: begin inv_mask[msg_dst] = 1'b1; inv_cnt++; ack_pend++; end
            default: begin rep_seen++; rep_dst = msg_dst; rep_data = msg_data; end
          endcase
        end
      end
    end
  end

  task automatic txn(input bit wr, input logic [1:0] src, input logic [3:0] blk);
    logic [NP-1:0] exp_inv;
    bit was_dirty;
    logic [1:0] owner;
    logic [DW-1:0] exp_data;
    int t;
    was_dirty = m_dirty[blk];
    owner = 0;
    for (int k = NP - 1; k >= 0; k--) if (m_pres[blk][k]) owner = 2'(k);
    exp_inv = (wr && !was_dirty) ? (m_pres[blk] & ~(NP'(1) << src)) : '0;
    exp_data = was_dirty ? (32'hC0DE_0000 + rec_total) : m_mem[blk];
    inv_mask = '0; inv_cnt = 0; rec_seen = 0; rep_seen = 0; acks_given = 0;
    busy_viol = 0; done_seen = 0; pend_at_done = 0;
    @(negedge clk); #1;
    chk(req_ready === 1'b1, "R8 ready when idle", req_ready, 1);
    req_valid = 1; req_write = wr; req_src = src; req_blk = blk;
    @(negedge clk); #1;
    req_valid = 0; busy_win = 1;
    t = 0;
    while (!done_seen && t < 200) begin @(negedge clk); #1; t++; end
    busy_win = 0;
    chk(done_seen, "R8 completion", done_seen, 1);
    chk(busy_viol == 0, "R8 ready low while busy", busy_viol, 0);
    chk(rep_seen == 1 && rep_dst == src, wr ? "R7/R5 reply dst" : "R3/R4 reply dst", rep_dst, src);
    chk(rep_data == exp_data, was_dirty ? "R4/R7 forwarded line" : "R3/R5 memory data", rep_data, exp_data);
    chk(inv_mask == exp_inv && inv_cnt == $countones(exp_inv), "R5 invalidation set", inv_mask, exp_inv);
    chk(pend_at_done == 0 && acks_given == inv_cnt, "R6 acks before reply", pend_at_done, 0);
    if (was_dirty) begin
      chk(rec_seen == 1 && rec_dst == owner, wr ? "R7 recall owner" : "R4 recall owner", rec_dst, owner);
      chk(rec_type == (wr ? 2'd1 : 2'd0), wr ? "R7 recall type" : "R4 recall type", rec_type, wr);
      chk(m_mem[blk] == exp_data, wr ? "R7 writeback" : "R4 writeback", m_mem[blk], exp_data);
    end else begin
      chk(rec_seen == 0, (m_pres[blk] == 0) ? "R1 no recall on empty" : "R2 no recall when clean", rec_seen, 0);
    end
    if (wr) begin m_dirty[blk] = 1; m_pres[blk] = NP'(1) << src; end
    else    begin m_dirty[blk] = 0; m_pres[blk] = m_pres[blk] | (NP'(1) << src); end
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] lf;
    for (int b = 0; b < NB; b++) begin
      m_pres[b] = '0; m_dirty[b] = 0; m_mem[b] = 32'h1000_0000 + 32'(b * 257);
    end
    inv_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(req_ready === 1'b1, "R1 ready after reset", req_ready, 1);
    chk(msg_valid === 1'b0 && done === 1'b0, "R1 quiet after reset", msg_valid, 0);
    // first touch of every block: no recall, no invalidation
    for (int b = 0; b < NB; b++) txn(1'b0, 2'(b % NP), 4'(b));
    // widely shared block, then a writer
    for (int p = 0; p < NP; p++) txn(1'b0, 2'(p), 4'd5);
    txn(1'b1, 2'd0, 4'd5);
    txn(1'b1, 2'd2, 4'd5);
    txn(1'b0, 2'd1, 4'd5);
    txn(1'b1, 2'd3, 4'd5);
    txn(1'b1, 2'd3, 4'd5);
    txn(1'b0, 2'd3, 4'd5);
    // sweep of every op/requester pair on every block state
    for (int b = 8; b < 10; b++)
      for (int w = 0; w < 2; w++)
        for (int p = 0; p < NP; p++)
          for (int q = 0; q < NP; q++) begin
            txn(w[0], 2'(p), 4'(b));
            txn(1'b0, 2'(q), 4'(b));
          end
    // pseudo-random mix on a few blocks
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      txn(lf[0], lf[2:1], {2'b00, lf[4:3]});
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule